// File: doc/BRIEF.md
# Collision-Line Heartbeat Pulse Generator

This block produces the signal-quality-error heartbeat that a 10 Mb/s half-duplex transceiver returns to its MAC after each transmitted frame. It watches the transmit enable line. When a frame ends, it waits a programmable number of bit times. It then raises a collision-pulse request for a programmable number of bit times. The request is meant to be ORed with the real collision detector before it reaches the MII collision pin. The MAC can then tell that the transmit path and its collision circuitry are alive.

The heartbeat is produced only when the link is half duplex, runs at 10 Mb/s and the disable control is low. If any of these three conditions stops holding, a pending or active pulse is dropped. A new frame that starts during the wait or during the pulse also cancels it. All timing is counted in a bit-time tick that is supplied from outside. The default counts are 10 ticks of delay and 10 ticks of pulse width, which is about 1 µs each at 10 Mb/s.

Top module: `sqe_heartbeat_gen`

## Requirements
- R1: While reset is asserted and right after reset is released, `sqe_col_req` is low.
- R2: A falling edge of `tx_en` (1 in one cycle, 0 in the next), seen while eligible, starts a delay of `DELAY_TICKS` asserted `bit_tick` cycles. The tick in the cycle where the falling edge is detected does not count toward the delay.
- R3: After the delay, `sqe_col_req` is high for exactly `PULSE_TICKS` asserted `bit_tick` cycles and then returns low. With a tick in every cycle, it is high in cycles DELAY_TICKS+1 to DELAY_TICKS+PULSE_TICKS after the detection edge.
- R4: When `full_duplex` is 1, no pulse is produced. A pending or active pulse is dropped, and `sqe_col_req` is low from the next cycle on.
- R5: When `speed_100` is 1, no pulse is produced, and a pending or active pulse is dropped.
- R6: When `hb_disable` is 1, no pulse is produced, and a pending or active pulse is dropped.
- R7: If `tx_en` is high during the delay or during the pulse, the pulse is cancelled and `sqe_col_req` is low in the next cycle. The next falling edge starts a fresh, complete sequence.
- R8: A cycle with `bit_tick` low does not advance the delay count or the pulse-width count.
- R9: Holding `tx_en` high, however long, produces no pulse. Only the end of a frame starts one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_en | input | 1 | Transmit enable from the MAC |
| full_duplex | input | 1 | 1 = full duplex, 0 = half duplex |
| speed_100 | input | 1 | 1 = 100 Mb/s, 0 = 10 Mb/s |
| hb_disable | input | 1 | 1 = heartbeat switched off |
| bit_tick | input | 1 | One-cycle strobe per bit time |
| sqe_col_req | output | 1 | Heartbeat request, to be ORed into the collision output |

## Verification
Frames end under each combination of gating inputs: half duplex at 10 Mb/s, full duplex, 100 Mb/s and heartbeat disabled. Comparing the results shows that each gate alone suppresses the pulse. Cycle-exact sampling against a tick in every cycle pins the delay and the width separately. A run with the tick held low before ticking resumes shows that both are counted in bit times and not in clocks. Frames restarted inside the delay and inside the pulse, a duplex change mid-delay and a long-held `tx_en` separate cancellation from a plain end of frame.

// File: rtl/sqe_pkg.sv
package sqe_pkg;
  typedef enum logic [1:0] {
    HB_IDLE  = 2'd0,
    HB_DELAY = 2'd1,
    HB_PULSE = 2'd2
  } hb_state_t;

  // counter width able to hold values 0..max(a,b)
  function automatic int hb_cnt_width(input int a, input int b);
    int m;
    m = (a > b) ? a : b;
    return (m < 2) ? 1 : $clog2(m + 1);
  endfunction

  // heartbeat is allowed only for 10 Mb/s half duplex with no disable
  function automatic logic hb_allowed(input logic fdx, input logic fast,
                                      input logic off);
    return !fdx && !fast && !off;
  endfunction
endpackage

// File: rtl/sqe_txen_edge.sv
module sqe_txen_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_en,
  output logic frame_end
);
  logic tx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tx_q <= 1'b0;
    else        tx_q <= tx_en;
  end

  assign frame_end = tx_q && !tx_en;
endmodule

// File: rtl/sqe_seq.sv
module sqe_seq
  import sqe_pkg::*;
#(
  parameter int DELAY_TICKS = 10,
  parameter int PULSE_TICKS = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_end,
  input  logic tx_busy,
  input  logic hb_en,
  input  logic bit_tick,
  output logic in_delay,
  output logic in_pulse
);
  localparam int CW = hb_cnt_width(DELAY_TICKS, PULSE_TICKS);
  localparam logic [CW-1:0] LAST_D = CW'(DELAY_TICKS - 1);
  localparam logic [CW-1:0] LAST_P = CW'(PULSE_TICKS - 1);

  hb_state_t st, st_n;
  logic [CW-1:0] cnt, cnt_n;
  logic cancel, delay_done, pulse_done;

  assign cancel     = !hb_en || tx_busy;
  assign delay_done = (st == HB_DELAY) && bit_tick && (cnt == LAST_D);
  assign pulse_done = (st == HB_PULSE) && bit_tick && (cnt == LAST_P);

  always_comb begin
    st_n  = st;
    cnt_n = cnt;
    if (cancel) begin
      st_n  = HB_IDLE;
      cnt_n = '0;
    end else begin
      unique case (st)
        HB_IDLE:  if (frame_end) begin st_n = HB_DELAY; cnt_n = '0; end
        HB_DELAY: if (delay_done) begin st_n = HB_PULSE; cnt_n = '0; end
                  else if (bit_tick) cnt_n = cnt + 1'b1;
        HB_PULSE: if (pulse_done) begin st_n = HB_IDLE; cnt_n = '0; end
                  else if (bit_tick) cnt_n = cnt + 1'b1;
        default:  begin st_n = HB_IDLE; cnt_n = '0; end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= HB_IDLE;
      cnt <= '0;
    end else begin
      st  <= st_n;
      cnt <= cnt_n;
    end
  end

  assign in_delay = (st == HB_DELAY);
  assign in_pulse = (st == HB_PULSE);

  // R2
  frame_end_starts_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && hb_en) |=> in_delay);
  // R3
  pulse_follows_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_pulse) |-> $past(in_delay));
  // R3
  pulse_cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_pulse |-> (cnt <= LAST_P));
  // R8
  no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_tick && !cancel && (in_delay || in_pulse)) |=> $stable(cnt) && $stable(st));
  // R7
  busy_cancels_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_busy |=> (!in_delay && !in_pulse));
endmodule

// File: rtl/sqe_heartbeat_gen.sv
module sqe_heartbeat_gen
  import sqe_pkg::*;
#(
  parameter int DELAY_TICKS = 10,
  parameter int PULSE_TICKS = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_en,
  input  logic full_duplex,
  input  logic speed_100,
  input  logic hb_disable,
  input  logic bit_tick,
  output logic sqe_col_req
);
  logic frame_end, hb_en, in_delay, in_pulse;

  assign hb_en = hb_allowed(full_duplex, speed_100, hb_disable);

  sqe_txen_edge u_edge (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .frame_end(frame_end)
  );

  sqe_seq #(.DELAY_TICKS(DELAY_TICKS), .PULSE_TICKS(PULSE_TICKS)) u_seq (
    .clk(clk), .rst_n(rst_n), .frame_end(frame_end), .tx_busy(tx_en),
    .hb_en(hb_en), .bit_tick(bit_tick), .in_delay(in_delay), .in_pulse(in_pulse)
  );

  assign sqe_col_req = in_pulse;

  // R4
  full_duplex_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full_duplex |=> !sqe_col_req);
  // R5
  fast_mode_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    speed_100 |=> !sqe_col_req);
  // R6
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hb_disable |=> !sqe_col_req);
  // R1
  always_comb begin
    reset_low_chk: assert (rst_n || !sqe_col_req);
  end
endmodule

// File: tb/sim_sqe_heartbeat_gen.sv
`timescale 1ns/1ps
module sim_sqe_heartbeat_gen;
  localparam int D = 10;
  localparam int P = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tx_en = 1'b0, full_duplex = 1'b0, speed_100 = 1'b0, hb_disable = 1'b0;
  logic bit_tick = 1'b1;
  logic sqe_col_req;
  int vectors = 0, errors = 0;

  always #4 clk = ~clk;

  sqe_heartbeat_gen #(.DELAY_TICKS(D), .PULSE_TICKS(P)) u0 (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .full_duplex(full_duplex),
    .speed_100(speed_100), .hb_disable(hb_disable), .bit_tick(bit_tick),
    .sqe_col_req(sqe_col_req)
  );

  task automatic chk(input logic act, input logic exp, input string req, input int k);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s sample %0d: sqe_col_req=%b expected %b", req, k, act, exp);
    end
  endtask

  // observe n cycles; sample k (after k-th posedge) expected high for lo<=k<=hi
  task automatic observe(input int n, input int lo, input int hi, input string req);
    for (int k = 1; k <= n; k++) begin
      @(posedge clk); @(negedge clk);
      chk(sqe_col_req, (k >= lo) && (k <= hi), req, k);
    end
  endtask

  task automatic send_frame(input int len);
    tx_en = 1'b1;
    repeat (len) @(negedge clk);
    tx_en = 1'b0;
  endtask

  task automatic t_reset;
    @(negedge clk); chk(sqe_col_req, 1'b0, "R1 in reset", 0);
    rst_n = 1'b1;
    observe(3, 0, -1, "R1 after reset");
  endtask

  task automatic t_normal;
    send_frame(6);
    observe(D + P + 3, D + 1, D + P, "R2/R3 heartbeat timing");
  endtask

  task automatic t_gated(input int which);
    full_duplex = (which == 0); speed_100 = (which == 1); hb_disable = (which == 2);
    send_frame(5);
    observe(D + P + 3, 0, -1, which == 0 ? "R4 full duplex" :
                              which == 1 ? "R5 100 Mb/s" : "R6 disabled");
    full_duplex = 1'b0; speed_100 = 1'b0; hb_disable = 1'b0;
  endtask

  task automatic t_cancel_delay;
    send_frame(4);
    observe(3, 0, -1, "R7 delay start");
    tx_en = 1'b1;
    observe(D + P + 2, 0, -1, "R7 cancel in delay");
    tx_en = 1'b0;
    observe(D + P + 3, D + 1, D + P, "R7 fresh after cancel");
  endtask

  task automatic t_cancel_pulse;
    send_frame(4);
    observe(D + 2, D + 1, D + P, "R7 pulse begins");
    tx_en = 1'b1;
    observe(4, 0, -1, "R7 cancel in pulse");
    tx_en = 1'b0;
    observe(D + P + 3, D + 1, D + P, "R7 fresh after pulse cancel");
  endtask

  task automatic t_tick_freeze;
    bit_tick = 1'b0;
    send_frame(4);
    observe(30, 0, -1, "R8 no ticks");
    bit_tick = 1'b1;
    observe(D + P + 2, D, D + P - 1, "R8 ticks resume");
  endtask

  task automatic t_mode_change;
    send_frame(4);
    observe(3, 0, -1, "R4 delay start");
    full_duplex = 1'b1;
    observe(2, 0, -1, "R4 duplex switch");
    full_duplex = 1'b0;
    observe(D + P + 2, 0, -1, "R4 dropped pulse");
  endtask

  task automatic t_long_tx;
    tx_en = 1'b1;
    observe(D + P + 8, 0, -1, "R9 tx held");
    tx_en = 1'b0;
    observe(D + P + 3, D + 1, D + P, "R9 end of long frame");
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_normal();
        t_gated(0);
        t_gated(1);
        t_gated(2);
        t_cancel_delay();
        t_cancel_pulse();
        t_tick_freeze();
        t_mode_change();
        t_long_tx();
      end
      begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run hung, actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule